// File: doc/BRIEF.md
# Interrupt Exception Entry Sequencer

This block sits beside a processor core and turns pending interrupt requests into the bus traffic of exception entry. Three source classes feed it: one non-maskable line, a group of external request lines and a group of on-chip peripheral requests. Each maskable line carries its own 4-bit priority level. Every class first passes through a delay line whose depth models that class's check and judgement stages. The survivors are then ranked in one registered decision against the interrupt mask held in the status register.

Once a request wins, the sequencer waits until the core reports that its current sequence has finished and no one-instruction hold-off is active. It then steps through a fixed order of memory work: save the status register below the stack pointer, save the program counter below that, and read the handler address from the vector table. The new mask is written back, and a single strobe starts the handler fetch, with the new program counter, stack pointer and vector number on the outputs. Memory uses a plain request/acknowledge port for 32-bit accesses, and each access may stretch over any number of wait cycles.

Top module: `irq_entry_seq`

## Requirements
- R1: After a synchronous reset, mem_req_o, sr_we_o and fetch_o are low and pc_new_o, sp_new_o and vec_o are zero.
- R2: With busy_i and inhibit_i low, fetch_o rises exactly D + 9 + m1 + m2 + m3 clock cycles after the clock edge that first samples a request. D is 2 for the non-maskable line, 4 for external lines and 2 for peripheral lines, and mk is the number of cycles access k keeps mem_req_o high. With one-cycle accesses this is a minimum of D + 12.
- R3: While busy_i or inhibit_i is high, no entry starts. Entry starts at the first clock edge at which both are low that is also at least D + 1 edges after the request was sampled, and every hold-off cycle beyond that point adds one cycle to the R2 latency.
- R4: The three accesses happen in a fixed order. First, a write of sr_i to sp_i − 4. Second, a write of pc_i to sp_i − 8. Third, a read at vbr_i + 4 × vector number. The stack pointer and vbr_i are longword aligned, so every address has bits [1:0] equal to 0.
- R5: Once raised, mem_req_o stays high with mem_addr_o, mem_we_o and mem_wdata_o unchanged until the cycle in which mem_ack_i is high. It drops on the following edge.
- R6: A maskable request is accepted only when its level is strictly greater than sr_i[7:4]. A request at or below the mask produces no bus access and no fetch_o.
- R7: After the status-register write completes, sr_we_o pulses for one cycle. sr_new_o then equals the saved status register with bits [7:4] replaced by the accepted level, or by 15 for the non-maskable source.
- R8: A rising edge on nmi_i is accepted whatever the mask. Holding nmi_i high afterwards causes no second entry.
- R9: fetch_o is a one-cycle pulse, never coincident with mem_req_o. At that pulse, pc_new_o holds the word read from the vector table, sp_new_o holds sp_i − 8 and vec_o holds the vector number.
- R10: The non-maskable source beats every maskable one. Among maskable requests the highest level wins. On equal levels, external lines beat peripheral lines and lower indices beat higher ones. Vector numbers are 11 for the non-maskable source, 64 + i for external line i and 96 + j for peripheral line j.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_i | input | 1 | Non-maskable request, edge sensitive |
| irq_req_i | input | N_IRQ | External request lines, level sensitive |
| irq_lvl_i | input | N_IRQ*4 | Priority level of each external line, 4 bits per line |
| per_req_i | input | N_PER | Peripheral request lines, level sensitive |
| per_lvl_i | input | N_PER*4 | Priority level of each peripheral line, 4 bits per line |
| busy_i | input | 1 | Core sequence in progress; holds off entry |
| inhibit_i | input | 1 | One-instruction interrupt hold-off |
| sr_i | input | DW | Current status register; bits [7:4] are the mask |
| pc_i | input | AW | Program counter value to save |
| sp_i | input | AW | Stack pointer at entry |
| vbr_i | input | AW | Vector table base address |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 for a write, 0 for a read |
| mem_addr_o | output | AW | Longword address of the access |
| mem_wdata_o | output | DW | Write data |
| mem_ack_i | input | 1 | Access completes in this cycle |
| mem_rdata_i | input | DW | Read data, valid with mem_ack_i |
| sr_we_o | output | 1 | One-cycle strobe to load sr_new_o |
| sr_new_o | output | DW | Status register with the new mask |
| pc_new_o | output | AW | Handler address for the fetch |
| sp_new_o | output | AW | Stack pointer after the two saves |
| vec_o | output | 8 | Vector number of the accepted source |
| fetch_o | output | 1 | One-cycle strobe: start handler fetch |

## Verification
The latency is measured separately for each of the three source classes, with wait states from zero up to three cycles picked at random for each access. The all-zero case pins the minimum figure, and the mixed cases show that every access length adds exactly its own cycles. Hold-off runs use busy_i and inhibit_i separately. A hold-off shorter than the decision path must cost nothing, and a longer one must shift the start edge by exactly its own cycles.

Mask tests place a level equal to the mask next to one just above it, and the non-maskable source is tried under a full mask. Arbitration tests hold several sources at once: equal levels across classes, a higher-level peripheral against a lower external line, and the non-maskable source against a level-15 line. A non-maskable line held high must produce a single entry, which separates edge sensing from level sensing.

// File: rtl/ies_pkg.sv
package ies_pkg;
  localparam int LVL_W = 4;
  localparam int VEC_W = 8;

  typedef enum logic [3:0] {
    S_IDLE, S_A1, S_WSR, S_A2, S_WPC, S_A3, S_RVEC,
    S_A4, S_A5, S_A6, S_A7, S_A8
  } seq_state_t;

  typedef struct packed {
    logic             valid;
    logic             nmi;
    logic [LVL_W-1:0] lvl;
    logic [VEC_W-1:0] vec;
  } pick_t;
endpackage

// File: rtl/ies_sync.sv
module ies_sync #(
  parameter int W     = 1,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [DEPTH-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[DEPTH-1];
endmodule

// File: rtl/ies_arbiter.sv
module ies_arbiter
  import ies_pkg::*;
#(
  parameter int N_IRQ    = 4,
  parameter int N_PER    = 4,
  parameter int NMI_VEC  = 11,
  parameter int IRQ_VEC0 = 64,
  parameter int PER_VEC0 = 96
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   nmi_hit,
  input  logic [N_IRQ-1:0]       irq_v,
  input  logic [N_IRQ*LVL_W-1:0] irq_lvl,
  input  logic [N_PER-1:0]       per_v,
  input  logic [N_PER*LVL_W-1:0] per_lvl,
  input  logic [LVL_W-1:0]       mask,
  output pick_t                  pick_q
);
  pick_t            pick_d;
  logic [LVL_W-1:0] best;

  always_comb begin
    pick_d = '0;
    best   = mask;
    for (int i = 0; i < N_IRQ; i++) begin
      if (irq_v[i] && irq_lvl[i*LVL_W +: LVL_W] > best) begin
        best         = irq_lvl[i*LVL_W +: LVL_W];
        pick_d.valid = 1'b1;
        pick_d.lvl   = best;
        pick_d.vec   = VEC_W'(IRQ_VEC0 + i);
      end
    end
    for (int j = 0; j < N_PER; j++) begin
      if (per_v[j] && per_lvl[j*LVL_W +: LVL_W] > best) begin
        best         = per_lvl[j*LVL_W +: LVL_W];
        pick_d.valid = 1'b1;
        pick_d.lvl   = best;
        pick_d.vec   = VEC_W'(PER_VEC0 + j);
      end
    end
    if (nmi_hit) begin
      pick_d.valid = 1'b1;
      pick_d.nmi   = 1'b1;
      pick_d.lvl   = '1;
      pick_d.vec   = VEC_W'(NMI_VEC);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pick_q <= '0;
    else     pick_q <= pick_d;
  end
endmodule

// File: rtl/ies_seq.sv
module ies_seq
  import ies_pkg::*;
#(
  parameter int DW       = 32,
  parameter int AW       = 32,
  parameter int MASK_LSB = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  pick_t            pick,
  input  logic             busy_i,
  input  logic             inhibit_i,
  input  logic [DW-1:0]    sr_i,
  input  logic [AW-1:0]    pc_i,
  input  logic [AW-1:0]    sp_i,
  input  logic [AW-1:0]    vbr_i,
  input  logic             mem_ack_i,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic             take_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  output logic             sr_we_o,
  output logic [DW-1:0]    sr_new_o,
  output logic [AW-1:0]    pc_new_o,
  output logic [AW-1:0]    sp_new_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             fetch_o
);
  localparam logic [AW-1:0] WORD = AW'(4);

  seq_state_t       st;
  logic [LVL_W-1:0] lvl_r;
  logic [VEC_W-1:0] vec_r;
  logic [AW-1:0]    sp_r;
  logic [DW-1:0]    sr_mod;
  logic [AW-1:0]    vec_addr;

  assign take_o   = (st == S_IDLE) && pick.valid && !busy_i && !inhibit_i;
  assign vec_addr = vbr_i + {{(AW-VEC_W-2){1'b0}}, vec_r, 2'b00};

  always_comb begin
    sr_mod = sr_i;
    sr_mod[MASK_LSB +: LVL_W] = lvl_r;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      lvl_r       <= '0;
      vec_r       <= '0;
      sp_r        <= '0;
      mem_req_o   <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      sr_we_o     <= 1'b0;
      sr_new_o    <= '0;
      pc_new_o    <= '0;
      sp_new_o    <= '0;
      vec_o       <= '0;
      fetch_o     <= 1'b0;
    end else begin
      fetch_o <= 1'b0;
      sr_we_o <= 1'b0;
      case (st)
        S_IDLE: if (take_o) begin
          lvl_r <= pick.lvl;
          vec_r <= pick.vec;
          sp_r  <= sp_i;
          st    <= S_A1;
        end
        S_A1: begin
          sp_r        <= sp_r - WORD;
          mem_req_o   <= 1'b1;
          mem_we_o    <= 1'b1;
          mem_addr_o  <= sp_r - WORD;
          mem_wdata_o <= sr_i;
          st          <= S_WSR;
        end
        S_WSR: if (mem_ack_i) begin
          mem_req_o <= 1'b0;
          st        <= S_A2;
        end
        S_A2: begin
          sr_we_o     <= 1'b1;
          sr_new_o    <= sr_mod;
          sp_r        <= sp_r - WORD;
          mem_req_o   <= 1'b1;
          mem_we_o    <= 1'b1;
          mem_addr_o  <= sp_r - WORD;
          mem_wdata_o <= DW'(pc_i);
          st          <= S_WPC;
        end
        S_WPC: if (mem_ack_i) begin
          mem_req_o <= 1'b0;
          st        <= S_A3;
        end
        S_A3: begin
          mem_req_o  <= 1'b1;
          mem_we_o   <= 1'b0;
          mem_addr_o <= vec_addr;
          st         <= S_RVEC;
        end
        S_RVEC: if (mem_ack_i) begin
          mem_req_o <= 1'b0;
          pc_new_o  <= AW'(mem_rdata_i);
          st        <= S_A4;
        end
        S_A4: st <= S_A5;
        S_A5: st <= S_A6;
        S_A6: st <= S_A7;
        S_A7: st <= S_A8;
        S_A8: begin
          fetch_o  <= 1'b1;
          sp_new_o <= sp_r;
          vec_o    <= vec_r;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import ies_pkg::*;
#(
  parameter int N_IRQ        = 4,
  parameter int N_PER        = 4,
  parameter int DW           = 32,
  parameter int AW           = 32,
  parameter int MASK_LSB     = 4,
  parameter int JDG_CYC      = 2,
  parameter int IRQ_CHK_CYC  = 2,
  parameter int PER_CHK_CYC  = 1,
  parameter int PER_JDG_CYC  = 1,
  parameter int NMI_VEC      = 11,
  parameter int IRQ_VEC0     = 64,
  parameter int PER_VEC0     = 96
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   nmi_i,
  input  logic [N_IRQ-1:0]       irq_req_i,
  input  logic [N_IRQ*LVL_W-1:0] irq_lvl_i,
  input  logic [N_PER-1:0]       per_req_i,
  input  logic [N_PER*LVL_W-1:0] per_lvl_i,
  input  logic                   busy_i,
  input  logic                   inhibit_i,
  input  logic [DW-1:0]          sr_i,
  input  logic [AW-1:0]          pc_i,
  input  logic [AW-1:0]          sp_i,
  input  logic [AW-1:0]          vbr_i,
  output logic                   mem_req_o,
  output logic                   mem_we_o,
  output logic [AW-1:0]          mem_addr_o,
  output logic [DW-1:0]          mem_wdata_o,
  input  logic                   mem_ack_i,
  input  logic [DW-1:0]          mem_rdata_i,
  output logic                   sr_we_o,
  output logic [DW-1:0]          sr_new_o,
  output logic [AW-1:0]          pc_new_o,
  output logic [AW-1:0]          sp_new_o,
  output logic [VEC_W-1:0]       vec_o,
  output logic                   fetch_o
);
  localparam int NMI_DLY = JDG_CYC;
  localparam int IRQ_DLY = IRQ_CHK_CYC + JDG_CYC;
  localparam int PER_DLY = PER_CHK_CYC + PER_JDG_CYC;

  logic             nmi_s, nmi_s_q, nmi_pend, nmi_rise, take;
  logic [N_IRQ-1:0] irq_s;
  logic [N_PER-1:0] per_s;
  pick_t            pick;

  ies_sync #(.W(1), .DEPTH(NMI_DLY)) u_nmi_dly (
    .clk(clk), .rst(rst), .d(nmi_i), .q(nmi_s));
  ies_sync #(.W(N_IRQ), .DEPTH(IRQ_DLY)) u_irq_dly (
    .clk(clk), .rst(rst), .d(irq_req_i), .q(irq_s));
  ies_sync #(.W(N_PER), .DEPTH(PER_DLY)) u_per_dly (
    .clk(clk), .rst(rst), .d(per_req_i), .q(per_s));

  assign nmi_rise = nmi_s && !nmi_s_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_s_q  <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      nmi_s_q  <= nmi_s;
      nmi_pend <= nmi_rise || (nmi_pend && !(take && pick.nmi));
    end
  end

  ies_arbiter #(
    .N_IRQ(N_IRQ), .N_PER(N_PER), .NMI_VEC(NMI_VEC),
    .IRQ_VEC0(IRQ_VEC0), .PER_VEC0(PER_VEC0)
  ) u_arb (
    .clk(clk), .rst(rst), .nmi_hit(nmi_pend || nmi_rise),
    .irq_v(irq_s), .irq_lvl(irq_lvl_i), .per_v(per_s), .per_lvl(per_lvl_i),
    .mask(sr_i[MASK_LSB +: LVL_W]), .pick_q(pick));

  ies_seq #(.DW(DW), .AW(AW), .MASK_LSB(MASK_LSB)) u_seq (
    .clk(clk), .rst(rst), .pick(pick), .busy_i(busy_i), .inhibit_i(inhibit_i),
    .sr_i(sr_i), .pc_i(pc_i), .sp_i(sp_i), .vbr_i(vbr_i),
    .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i), .take_o(take),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .sr_we_o(sr_we_o), .sr_new_o(sr_new_o),
    .pc_new_o(pc_new_o), .sp_new_o(sp_new_o), .vec_o(vec_o), .fetch_o(fetch_o));
endmodule

// File: rtl/ies_checker.sv
module ies_checker #(
  parameter int DW       = 32,
  parameter int AW       = 32,
  parameter int MASK_LSB = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic          mem_ack_i,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic          fetch_o,
  input logic          sr_we_o,
  input logic [DW-1:0] sr_new_o,
  input logic [DW-1:0] sr_i
);
  // R5: request and its payload hold until acknowledged
  a_r5_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)
                                   && $stable(mem_we_o) && $stable(mem_wdata_o)));

  // R4: every access is longword aligned
  a_r4_aligned: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00));

  // R9: fetch strobe lasts one cycle
  a_r9_fetch_pulse: assert property (@(posedge clk) disable iff (rst)
    fetch_o |=> !fetch_o);

  // R9: fetch strobe never overlaps a bus access
  a_r9_fetch_bus_idle: assert property (@(posedge clk) disable iff (rst)
    fetch_o |-> !mem_req_o);

  // R7: the written mask never drops below the current one
  a_r7_mask_raise: assert property (@(posedge clk) disable iff (rst)
    sr_we_o |-> (sr_new_o[MASK_LSB +: 4] >= sr_i[MASK_LSB +: 4]));

  // R7: mask strobe is a single cycle
  a_r7_we_pulse: assert property (@(posedge clk) disable iff (rst)
    sr_we_o |=> !sr_we_o);
endmodule

bind irq_entry_seq ies_checker u_ies_chk (
  .clk(clk), .rst(rst), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_ack_i(mem_ack_i), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
  .fetch_o(fetch_o), .sr_we_o(sr_we_o), .sr_new_o(sr_new_o), .sr_i(sr_i));

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_IRQ = 4;
  localparam int N_PER = 4;
  localparam logic [31:0] KEY = 32'h5A5A_0000;
  localparam logic [31:0] SR_BASE = 32'h0000_0301;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic nmi_i = 1'b0;
  logic [N_IRQ-1:0]   irq_req_i = '0;
  logic [N_IRQ*4-1:0] irq_lvl_i = '0;
  logic [N_PER-1:0]   per_req_i = '0;
  logic [N_PER*4-1:0] per_lvl_i = '0;
  logic busy_i = 1'b0, inhibit_i = 1'b0;
  logic [31:0] sr_i = SR_BASE, pc_i = '0, sp_i = 32'h2000, vbr_i = '0;
  logic mem_req_o, mem_we_o, mem_ack_i = 1'b0;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i = '0;
  logic sr_we_o, fetch_o;
  logic [31:0] sr_new_o, pc_new_o, sp_new_o;
  logic [7:0] vec_o;

  irq_entry_seq dut_i (
    .clk(clk), .rst(rst), .nmi_i(nmi_i), .irq_req_i(irq_req_i), .irq_lvl_i(irq_lvl_i),
    .per_req_i(per_req_i), .per_lvl_i(per_lvl_i), .busy_i(busy_i), .inhibit_i(inhibit_i),
    .sr_i(sr_i), .pc_i(pc_i), .sp_i(sp_i), .vbr_i(vbr_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
    .sr_we_o(sr_we_o), .sr_new_o(sr_new_o), .pc_new_o(pc_new_o), .sp_new_o(sp_new_o),
    .vec_o(vec_o), .fetch_o(fetch_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_run = 0, n_fail = 0;
  int waits [3];
  logic [31:0] addr_log [3], data_log [3];
  logic        we_log [3];
  int          len_log [3];
  int acc_idx = 0, cur_len = 0, wl = 0, fetch_cnt = 0;
  bit in_acc = 0, keep_nmi = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // memory responder and bench-side status register
  always @(negedge clk) begin
    if (fetch_o) fetch_cnt++;
    if (sr_we_o) sr_i = sr_new_o;
    if (mem_ack_i) begin
      mem_ack_i = 1'b0;
    end else if (mem_req_o) begin
      if (!in_acc) begin
        in_acc = 1; cur_len = 0;
        wl = (acc_idx < 3) ? waits[acc_idx] : 0;
      end
      cur_len++;
      if (wl == 0) begin
        mem_ack_i = 1'b1;
        mem_rdata_i = mem_addr_o ^ KEY;
        if (acc_idx < 3) begin
          addr_log[acc_idx] = mem_addr_o;
          data_log[acc_idx] = mem_wdata_o;
          we_log[acc_idx]   = mem_we_o;
          len_log[acc_idx]  = cur_len;
        end
        acc_idx++;
        in_acc = 0;
      end else begin
        wl--;
      end
    end
  end

  function automatic int src_dly(input int src);
    return (src == 1) ? 4 : 2;
  endfunction

  function automatic int exp_lat(input int d, input int hold, input int w0, input int w1, input int w2);
    int s = (hold > d + 1) ? hold : d + 1;
    return s + 8 + (w0 + 1) + (w1 + 1) + (w2 + 1);
  endfunction

  // src: 0 non-maskable, 1 external line, 2 peripheral line
  task automatic trial(input int src, input int idx, input int lvl, input int mask,
                       input int hold, input bit use_inh, input bit expect_acc,
                       input int exp_vec, input int exp_lvl, input string tag);
    logic [31:0] sr0, sp0, pc0, vbr0, vaddr;
    int cnt, f0, lat_exp;
    bit seen;
    @(negedge clk);
    for (int k = 0; k < 3; k++) waits[k] = $urandom_range(0, 3);
    sr0  = (SR_BASE & ~32'hF0) | (32'(mask) << 4);
    sp0  = 32'h2000 + (32'($urandom_range(0, 255)) << 2);
    pc0  = $urandom;
    vbr0 = $urandom & 32'hFFFF_F000;
    sr_i = sr0; sp_i = sp0; pc_i = pc0; vbr_i = vbr0;
    acc_idx = 0;
    f0 = fetch_cnt;
    case (src)
      0: nmi_i = 1'b1;
      1: begin irq_req_i[idx] = 1'b1; irq_lvl_i[idx*4 +: 4] = 4'(lvl); end
      default: begin per_req_i[idx] = 1'b1; per_lvl_i[idx*4 +: 4] = 4'(lvl); end
    endcase
    if (hold > 0) begin
      if (use_inh) inhibit_i = 1'b1; else busy_i = 1'b1;
    end
    @(posedge clk);
    cnt = 0; seen = 0;
    while (!seen && cnt < 100) begin
      @(negedge clk);
      if (hold > 0 && cnt == hold - 1) begin busy_i = 1'b0; inhibit_i = 1'b0; end
      if (fetch_o) seen = 1;
      else begin @(posedge clk); cnt++; end
    end
    if (expect_acc) begin
      lat_exp = exp_lat(src_dly(src), hold, waits[0], waits[1], waits[2]);
      vaddr = vbr0 + 32'(exp_vec) * 4;
      if (hold > 0) check(seen && cnt == lat_exp, {tag, " R3 latency with hold-off"}, cnt, lat_exp);
      else          check(seen && cnt == lat_exp, {tag, " R2 latency"}, cnt, lat_exp);
      check(vec_o == 8'(exp_vec), {tag, " R10 vector"}, vec_o, exp_vec);
      check(acc_idx == 3 && we_log[0] && addr_log[0] == sp0 - 4 && data_log[0] == sr0,
            {tag, " R4 status save"}, addr_log[0], sp0 - 4);
      check(we_log[1] && addr_log[1] == sp0 - 8 && data_log[1] == pc0,
            {tag, " R4 pc save"}, addr_log[1], sp0 - 8);
      check(!we_log[2] && addr_log[2] == vaddr, {tag, " R4 vector read"}, addr_log[2], vaddr);
      check(len_log[0] == waits[0] + 1 && len_log[1] == waits[1] + 1 && len_log[2] == waits[2] + 1,
            {tag, " R5 access lengths"}, len_log[0] + len_log[1] + len_log[2],
            waits[0] + waits[1] + waits[2] + 3);
      check(pc_new_o == (vaddr ^ KEY), {tag, " R9 handler address"}, pc_new_o, vaddr ^ KEY);
      check(sp_new_o == sp0 - 8, {tag, " R9 stack pointer"}, sp_new_o, sp0 - 8);
      check(sr_i == ((sr0 & ~32'hF0) | (32'(exp_lvl) << 4)), {tag, " R7 new mask"},
            sr_i, (sr0 & ~32'hF0) | (32'(exp_lvl) << 4));
      @(negedge clk);
      check(!fetch_o, {tag, " R9 strobe width"}, fetch_o, 0);
    end else begin
      check(!seen && acc_idx == 0, {tag, " R6 masked request ignored"}, acc_idx, 0);
    end
    irq_req_i = '0; per_req_i = '0; busy_i = 1'b0; inhibit_i = 1'b0;
    if (!keep_nmi) nmi_i = 1'b0;
    repeat (keep_nmi ? 40 : 12) @(negedge clk);
    check(fetch_cnt == f0 + (expect_acc ? 1 : 0), {tag, " R8 single entry"}, fetch_cnt - f0,
          expect_acc ? 1 : 0);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    check(!mem_req_o && !fetch_o && !sr_we_o && pc_new_o == 0 && sp_new_o == 0 && vec_o == 0,
          "R1 reset state", {mem_req_o, fetch_o, sr_we_o}, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    trial(0, 0, 0, 15, 0, 0, 1, 11, 15, "nmi full mask R8");
    for (int k = 0; k < 3; k++) waits[k] = 0;
    trial(1, 2, 6, 6, 0, 0, 0, 0, 0, "irq level equals mask R6");
    trial(1, 2, 7, 6, 0, 0, 1, 66, 7, "irq level above mask R6");
    trial(2, 1, 9, 3, 0, 0, 1, 97, 9, "peripheral R2");
    trial(1, 0, 4, 0, 9, 0, 1, 64, 4, "busy hold-off R3");
    trial(2, 3, 4, 0, 12, 1, 1, 99, 4, "inhibit hold-off R3");
    trial(1, 3, 4, 0, 3, 0, 1, 67, 4, "short hold-off R3");

    // R10 ties and cross-class ranking
    @(negedge clk); irq_req_i[1] = 1'b1; irq_lvl_i[7:4] = 4'd5;
    trial(2, 0, 5, 0, 10, 0, 1, 65, 5, "tie external beats peripheral R10");
    @(negedge clk); irq_req_i[0] = 1'b1; irq_lvl_i[3:0] = 4'd3;
    trial(2, 1, 7, 0, 10, 0, 1, 97, 7, "higher peripheral wins R10");
    @(negedge clk); irq_req_i[2] = 1'b1; irq_lvl_i[11:8] = 4'd15;
    trial(0, 0, 0, 0, 10, 0, 1, 11, 15, "nmi beats level 15 R10");

    keep_nmi = 1;
    trial(0, 0, 0, 2, 0, 0, 1, 11, 15, "nmi held high R8");
    keep_nmi = 0;
    nmi_i = 1'b0;
    repeat (6) @(negedge clk);

    for (int t = 0; t < 24; t++) begin
      int src, idx, mask, lvl, hold;
      src  = $urandom_range(0, 2);
      idx  = $urandom_range(0, 3);
      mask = $urandom_range(0, 13);
      lvl  = mask + 1 + $urandom_range(0, 14 - mask);
      hold = ($urandom_range(0, 2) == 0) ? $urandom_range(1, 12) : 0;
      trial(src, idx, lvl, mask, hold, 1'($urandom_range(0, 1)), 1,
            (src == 0) ? 11 : (src == 1) ? 64 + idx : 96 + idx,
            (src == 0) ? 15 : lvl, "random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule